// File: doc/BRIEF.md
# Prefix Page Instruction Decoder

This block sits behind an instruction byte fetcher. It takes one byte on every clock where `in_valid` is high and splits the byte stream into instructions. Each instruction is reported as a 2-bit page number, one opcode byte and up to four operand bytes. Three reserved byte values act as page prefixes. When such a byte leads an instruction, the decoder absorbs it and records its page. The byte that follows is then the opcode. Any other leading byte is itself the opcode on page 0. This reduces one-byte and two-byte opcodes to the same pair: a page and a single opcode byte.

The page and the two top bits of the opcode give the operand length. The decoder collects that many bytes and then raises `out_done` for one cycle. Page, opcode, operands and length appear together on registered outputs, which hold their values until the next instruction completes.

The controller has three named states:

- **ST_PREFIX** is phase 0, which inspects a possible prefix byte.
- **ST_OPCODE** is phase 1 after a prefix.
- **ST_OPERAND** collects operand bytes.

The transitions are:

- **take_prefix**: ST_PREFIX to ST_OPCODE.
- **take_opcode_short**: ST_PREFIX or ST_OPCODE back to ST_PREFIX, for an instruction with no operands.
- **take_opcode_long**: ST_PREFIX or ST_OPCODE to ST_OPERAND.
- **take_last_operand**: ST_OPERAND to ST_PREFIX.
- **hold**: no valid byte, so the state does not change.

Top module: `page_prefix_decoder`

## Requirements
- R1: At the start of an instruction, byte 0x17 selects page 1, byte 0x27 selects page 2 and byte 0x37 selects page 3. The next accepted byte is the opcode.
- R2: At the start of an instruction, any other byte selects page 0, and that byte is itself the opcode.
- R3: After a prefix, the next accepted byte is always the opcode, even if its value is a prefix value. Prefixes never chain.
- R4: On page 0, an opcode with bit 7 clear takes 1 operand byte (8-bit indexed or 8-bit immediate). An opcode with bit 7 set takes none.
- R5: On page 1, an opcode with bits 7:6 equal to 2'b11 takes 4 operand bytes (two 2-byte operands). Every other page 1 opcode takes 2 bytes (16-bit indexed or extended).
- R6: Page 2 opcodes take no operands. Page 3 opcodes take 2 bytes when bit 7 is set and none otherwise. So the pair 0x37 0x10 decodes as page 3, opcode 0x10, with no operands.
- R7: The first operand byte accepted appears in `out_operands[7:0]`, the next in [15:8], and so on. Unused bytes read zero, and `out_len` gives the operand byte count.
- R8: `out_done` is high for exactly the one cycle after the edge that accepted the last byte of an instruction. The other outputs change only then and hold their values otherwise.
- R9: A byte presented while `in_valid` is low is ignored. It changes neither the state nor any output.
- R10: A synchronous reset returns the decoder to phase 0, clears the page and the operand count, and zeroes all outputs. A partly received instruction is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | `in_byte` is accepted on this edge |
| in_byte | input | 8 | Instruction stream byte |
| out_done | output | 1 | One-cycle strobe: an instruction completed |
| out_page | output | 2 | Page of the completed instruction |
| out_opcode | output | 8 | Opcode byte |
| out_operands | output | 8*MAX_OPND_BYTES | Operand bytes, first byte in the low lane |
| out_len | output | $clog2(MAX_OPND_BYTES+1) | Operand byte count |

## Verification
The bench targets a prefix value used as the opcode after a prefix. A design that chains prefixes would skip that opcode and report the wrong page and length. Bytes presented with `in_valid` low between a prefix and its opcode are also covered. A decoder that samples the byte without qualifying it would take 0x27 as the opcode. Back-to-back zero-operand instructions must raise `out_done` on consecutive cycles. A decoder that forces an idle cycle, or drops the strobe, would fall out of step with the reference model. A reset in the middle of an instruction must discard the collected operand bytes. Otherwise the next byte would be counted as a leftover operand instead of a fresh page 0 opcode.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    typedef enum logic [1:0] {
        ST_PREFIX  = 2'd0,
        ST_OPCODE  = 2'd1,
        ST_OPERAND = 2'd2
    } pdec_state_e;

    typedef logic [1:0] page_t;

    localparam logic [7:0] PFX_PAGE1 = 8'h17;
    localparam logic [7:0] PFX_PAGE2 = 8'h27;
    localparam logic [7:0] PFX_PAGE3 = 8'h37;

endpackage

// File: rtl/pdec_prefix_detect.sv
module pdec_prefix_detect
    import pdec_pkg::*;
(
    input  logic [7:0] byte_i,
    output logic       hit_o,
    output page_t      page_o
);

    always_comb begin
        hit_o  = 1'b1;
        page_o = 2'd0;
        case (byte_i)
            PFX_PAGE1: page_o = 2'd1;
            PFX_PAGE2: page_o = 2'd2;
            PFX_PAGE3: page_o = 2'd3;
            default:   hit_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/pdec_len_decode.sv
module pdec_len_decode
    import pdec_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  page_t            page_i,
    input  logic [1:0]       opc_top_i,
    output logic [LEN_W-1:0] len_o
);

    localparam logic [LEN_W-1:0] LEN_NONE = LEN_W'(0);
    localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
    localparam logic [LEN_W-1:0] LEN_WORD = LEN_W'(2);
    localparam logic [LEN_W-1:0] LEN_PAIR = LEN_W'(4);

    always_comb begin
        unique case (page_i)
            2'd0:    len_o = opc_top_i[1] ? LEN_NONE : LEN_ONE;
            2'd1:    len_o = (opc_top_i == 2'b11) ? LEN_PAIR : LEN_WORD;
            2'd2:    len_o = LEN_NONE;
            default: len_o = opc_top_i[1] ? LEN_WORD : LEN_NONE;
        endcase
    end

endmodule

// File: rtl/pdec_opnd_buf.sv
module pdec_opnd_buf #(
    parameter int SLOTS = 4,
    parameter int IDX_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear_i,
    input  logic               wr_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [7:0]         byte_i,
    output logic [SLOTS*8-1:0] merged_o
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [7:0] slot_q;
        logic       hit;

        assign hit = wr_i && (idx_i == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                slot_q <= 8'h00;
            end else if (hit) begin
                slot_q <= byte_i;
            end
        end

        assign merged_o[g*8 +: 8] = hit ? byte_i : slot_q;
    end

    // R7
    slots_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> ((merged_o >> 8) == '0));

endmodule

// File: rtl/pdec_fsm.sv
module pdec_fsm
    import pdec_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int LEN_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_i,
    input  logic [7:0]         byte_i,
    input  logic               pfx_hit_i,
    input  page_t              pfx_page_i,
    input  logic [LEN_W-1:0]   dec_len_i,
    input  logic [SLOTS*8-1:0] merged_i,
    output page_t              dec_page_o,
    output logic               buf_clear_o,
    output logic               buf_wr_o,
    output logic [LEN_W-1:0]   buf_idx_o,
    output logic               done_o,
    output page_t              page_o,
    output logic [7:0]         opcode_o,
    output logic [SLOTS*8-1:0] operands_o,
    output logic [LEN_W-1:0]   len_o
);

    pdec_state_e      state_q, state_d;
    page_t            page_q;
    logic [7:0]       opc_q;
    logic [LEN_W-1:0] need_q;
    logic [LEN_W-1:0] cnt_q;
    logic             opc_take;
    logic             last_take;
    logic             emit;
    logic             zero_len;

    assign zero_len   = (dec_len_i == '0);
    assign dec_page_o = (state_q == ST_OPCODE) ? page_q : 2'd0;

    // next-state and transition decode
    always_comb begin
        state_d   = state_q;
        opc_take  = 1'b0;
        last_take = 1'b0;
        unique case (state_q)
            ST_PREFIX: begin
                if (valid_i) begin
                    if (pfx_hit_i) begin
                        state_d = ST_OPCODE;                     // take_prefix
                    end else begin
                        opc_take = 1'b1;
                        state_d  = zero_len ? ST_PREFIX : ST_OPERAND;
                    end
                end
            end
            ST_OPCODE: begin
                if (valid_i) begin
                    opc_take = 1'b1;
                    state_d  = zero_len ? ST_PREFIX : ST_OPERAND;
                end
            end
            ST_OPERAND: begin
                if (valid_i && ((cnt_q + LEN_W'(1)) == need_q)) begin
                    last_take = 1'b1;
                    state_d   = ST_PREFIX;                       // take_last_operand
                end
            end
            default: state_d = ST_PREFIX;
        endcase
    end

    assign emit        = (opc_take && zero_len) || last_take;
    assign buf_clear_o = opc_take;
    assign buf_wr_o    = valid_i && (state_q == ST_OPERAND);
    assign buf_idx_o   = cnt_q;

    // state register and per-instruction context
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PREFIX;
            page_q  <= 2'd0;
            opc_q   <= 8'h00;
            need_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PREFIX && valid_i && pfx_hit_i) begin
                page_q <= pfx_page_i;
            end
            if (opc_take) begin
                opc_q  <= byte_i;
                need_q <= dec_len_i;
                cnt_q  <= '0;
                if (state_q == ST_PREFIX) begin
                    page_q <= 2'd0;
                end
            end else if (buf_wr_o) begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
        end
    end

    // registered result port
    always_ff @(posedge clk) begin
        if (rst) begin
            done_o     <= 1'b0;
            page_o     <= 2'd0;
            opcode_o   <= 8'h00;
            operands_o <= '0;
            len_o      <= '0;
        end else begin
            done_o <= emit;
            if (emit) begin
                page_o     <= opc_take ? dec_page_o : page_q;
                opcode_o   <= opc_take ? byte_i : opc_q;
                operands_o <= opc_take ? '0 : merged_i;
                len_o      <= opc_take ? '0 : need_q;
            end
        end
    end

    // R8
    done_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(valid_i));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(state_q) && $stable(cnt_q) && !done_o && $stable(opcode_o)));

    // R3
    opcode_after_prefix_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPCODE && valid_i) |=> (state_q != ST_OPCODE));

    // R4
    page0_len_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && page_o == 2'd0) |-> (len_o <= LEN_W'(1)));

    // R6
    page2_len_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && page_o == 2'd2) |-> (len_o == '0));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPERAND) |-> (cnt_q < need_q));

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (state_q == ST_PREFIX && cnt_q == '0 && page_q == 2'd0 && !done_o));

endmodule

// File: rtl/page_prefix_decoder.sv
module page_prefix_decoder
    import pdec_pkg::*;
#(
    parameter int MAX_OPND_BYTES = 4,
    localparam int LEN_W  = $clog2(MAX_OPND_BYTES + 1),
    localparam int OPND_W = 8 * MAX_OPND_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              out_done,
    output logic [1:0]        out_page,
    output logic [7:0]        out_opcode,
    output logic [OPND_W-1:0] out_operands,
    output logic [LEN_W-1:0]  out_len
);

    logic              pfx_hit;
    page_t             pfx_page;
    page_t             dec_page;
    logic [LEN_W-1:0]  dec_len;
    logic              buf_clear;
    logic              buf_wr;
    logic [LEN_W-1:0]  buf_idx;
    logic [OPND_W-1:0] merged;

    pdec_prefix_detect i_pfx (
        .byte_i (in_byte),
        .hit_o  (pfx_hit),
        .page_o (pfx_page)
    );

    pdec_len_decode #(.LEN_W(LEN_W)) i_len (
        .page_i    (dec_page),
        .opc_top_i (in_byte[7:6]),
        .len_o     (dec_len)
    );

    pdec_opnd_buf #(.SLOTS(MAX_OPND_BYTES), .IDX_W(LEN_W)) i_buf (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (buf_clear),
        .wr_i     (buf_wr),
        .idx_i    (buf_idx),
        .byte_i   (in_byte),
        .merged_o (merged)
    );

    pdec_fsm #(.SLOTS(MAX_OPND_BYTES), .LEN_W(LEN_W)) i_fsm (
        .clk         (clk),
        .rst         (rst),
        .valid_i     (in_valid),
        .byte_i      (in_byte),
        .pfx_hit_i   (pfx_hit),
        .pfx_page_i  (pfx_page),
        .dec_len_i   (dec_len),
        .merged_i    (merged),
        .dec_page_o  (dec_page),
        .buf_clear_o (buf_clear),
        .buf_wr_o    (buf_wr),
        .buf_idx_o   (buf_idx),
        .done_o      (out_done),
        .page_o      (out_page),
        .opcode_o    (out_opcode),
        .operands_o  (out_operands),
        .len_o       (out_len)
    );

endmodule

// File: tb/test_page_prefix_decoder.sv
`timescale 1ns/1ps
module test_page_prefix_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        out_done;
    logic [1:0]  out_page;
    logic [7:0]  out_opcode;
    logic [31:0] out_operands;
    logic [2:0]  out_len;

    page_prefix_decoder i_page_prefix_decoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .out_done(out_done), .out_page(out_page), .out_opcode(out_opcode),
        .out_operands(out_operands), .out_len(out_len)
    );

    always #2 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit chk_en  = 0;
    bit ended   = 0;

    // behavioural reference model
    int          ph, mpage, mopc, mneed, mgot;
    logic [31:0] mbuf;
    logic        exp_done;
    int          exp_page, exp_opc, exp_len;
    logic [31:0] exp_opnd;

    function automatic int blen(int pg, int op);
        if (pg == 0) return (op < 128) ? 1 : 0;
        if (pg == 1) return (op >= 192) ? 4 : 2;
        if (pg == 2) return 0;
        return (op >= 128) ? 2 : 0;
    endfunction

    task automatic model_finish();
        exp_done = 1'b1;
        exp_page = mpage;
        exp_opc  = mopc;
        exp_opnd = mbuf;
        exp_len  = mneed;
        ph       = 0;
    endtask

    task automatic model_opcode(int b);
        mopc  = b;
        mneed = blen(mpage, b);
        mgot  = 0;
        mbuf  = '0;
        if (mneed == 0) model_finish();
        else ph = 2;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; mpage = 0; mopc = 0; mneed = 0; mgot = 0; mbuf = '0;
            exp_done = 0; exp_page = 0; exp_opc = 0; exp_opnd = '0; exp_len = 0;
            chk_en = 1;
        end else begin
            exp_done = 0;
            if (in_valid) begin
                if (ph == 0) begin
                    if (in_byte == 8'h17)      begin mpage = 1; ph = 1; end
                    else if (in_byte == 8'h27) begin mpage = 2; ph = 1; end
                    else if (in_byte == 8'h37) begin mpage = 3; ph = 1; end
                    else begin mpage = 0; model_opcode(int'(in_byte)); end
                end else if (ph == 1) begin
                    model_opcode(int'(in_byte));
                end else begin
                    mbuf[mgot*8 +: 8] = in_byte;
                    mgot++;
                    if (mgot == mneed) model_finish();
                end
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_en && !ended) begin
            check("R8 done strobe", 32'(out_done), 32'(exp_done));
            check("R1/R2 page", 32'(out_page), 32'(exp_page));
            check("R3 opcode", 32'(out_opcode), 32'(exp_opc));
            check("R4 R5 R6 length", 32'(out_len), 32'(exp_len));
            check("R7 operands", out_operands, exp_opnd);
        end
    end

    task automatic send(logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        ended = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 reset done", 32'(out_done), 0);
        check("R10 reset page", 32'(out_page), 0);
        check("R10 reset len", 32'(out_len), 0);
        check("R10 reset operands", out_operands, 0);

        send(8'h37); send(8'h10);
        check("R6 COMB done", 32'(out_done), 1);
        check("R1 COMB page", 32'(out_page), 3);
        check("R6 COMB opcode", 32'(out_opcode), 32'h10);
        check("R6 COMB length", 32'(out_len), 0);

        send(8'h04); send(8'hAB);
        check("R2 page", 32'(out_page), 0);
        check("R4 length", 32'(out_len), 1);
        check("R7 operand", out_operands, 32'hAB);

        @(negedge clk);
        check("R8 single pulse", 32'(out_done), 0);
        check("R8 hold opcode", 32'(out_opcode), 32'h04);

        send(8'h80);
        check("R4 no operand", 32'(out_len), 0);
        check("R7 zero operands", out_operands, 0);

        send(8'h17); send(8'h14); send(8'h34); send(8'h12);
        check("R5 length", 32'(out_len), 2);
        check("R7 packing", out_operands, 32'h1234);

        send(8'h17);
        in_byte = 8'h27;
        repeat (2) @(negedge clk);
        check("R9 ignored byte", 32'(out_done), 0);
        send(8'hC0); send(8'h11); send(8'h22); send(8'h33); send(8'h44);
        check("R9 opcode after gap", 32'(out_opcode), 32'hC0);
        check("R5 pair length", 32'(out_len), 4);
        check("R7 four bytes", out_operands, 32'h44332211);

        send(8'h17); send(8'h27); send(8'h5A); send(8'hA5);
        check("R3 prefix as opcode", 32'(out_opcode), 32'h27);
        check("R3 page", 32'(out_page), 1);

        send(8'h27); send(8'h45);
        check("R6 page 2", 32'(out_page), 2);
        check("R6 page 2 length", 32'(out_len), 0);

        send(8'h37); send(8'h90); send(8'hEE); send(8'hDD);
        check("R6 page 3 length", 32'(out_len), 2);

        send(8'h17); send(8'h04); send(8'h99);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 mid reset len", 32'(out_len), 0);
        check("R10 mid reset opcode", 32'(out_opcode), 0);
        send(8'h04); send(8'h55);
        check("R10 fresh opcode", 32'(out_opcode), 32'h04);
        check("R10 fresh operand", out_operands, 32'h55);

        send(8'h81); send(8'h82);
        check("R8 back to back", 32'(out_done), 1);

        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 8);
            in_valid = ($urandom % 4) != 0;
            if (r == 0)      in_byte = 8'h17;
            else if (r == 1) in_byte = 8'h27;
            else if (r == 2) in_byte = 8'h37;
            else             in_byte = 8'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule